// File: doc/BRIEF.md
# MESI Snooping Write-Back Cache Controller

This block sits between one processor and a shared snooping bus. It keeps a small direct-mapped cache of one-word blocks, and each block holds one of four coherence states: Invalid, Shared, Exclusive or Modified. The processor issues one read or write at a time and holds it until `cpu_ready` pulses. The controller answers hits locally. Misses, and writes to blocks it does not own, go to the bus as single-cycle granted transactions. A dirty victim is written back before the new block is fetched.

The same array is watched by a snoop port. Another master's read-shared or read-exclusive on the bus is presented there. In the same cycle, the controller drives its contribution to the wired-OR shared line. When it holds the only dirty copy, it supplies the block on the flush outputs. The state change takes effect at the next clock edge. A read miss samples the shared line to choose between Shared and Exclusive. A later write to an Exclusive block then needs no bus cycle.

The control sequencer has five states. In IDLE it accepts a request and looks it up. EVICT writes back the dirty victim. FETCH performs the read-shared fill. OWN performs the read-exclusive that grants ownership. DONE pulses `cpu_ready`. The transitions are as follows:
- IDLE goes to DONE on a read hit, or on a write hit to an Exclusive or Modified block.
- IDLE goes to OWN on a write to a Shared block, or on a write miss with a clean victim.
- IDLE goes to FETCH on a read miss with a clean victim.
- IDLE goes to EVICT on a miss whose victim is Modified.
- EVICT goes to FETCH or OWN once the write-back is granted, or at once if a snoop has already cleaned the victim.
- FETCH and OWN go to DONE on grant.
- DONE goes back to IDLE.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset, every block is Invalid and `cpu_ready`, `bus_req`, `shr_out` and `flush_valid` are low.
- R2: A read miss issues a read-shared transaction (`bus_cmd` = 1). The block fills with `bus_rdata`. It becomes Exclusive if `shr_in` is low in the grant cycle and Shared if `shr_in` is high. The read returns the filled word.
- R3: A read hit returns the cached word with no bus transaction. `cpu_ready` rises one cycle after the request is accepted.
- R4: A write to an Exclusive block updates the word and makes the block Modified with no bus transaction.
- R5: A write to a Shared block, or a write miss, issues a read-exclusive transaction (`bus_cmd` = 2). Afterwards the block is Modified and holds the written word.
- R6: A miss whose victim is Modified first issues a write-back (`bus_cmd` = 3) carrying the victim's address and data, then the fill. A clean victim is dropped with no write-back.
- R7: A snooped read-shared (`snp_cmd` = 1) that hits a valid block raises `shr_out` in that cycle. A Modified block also raises `flush_valid` with its data. Modified and Exclusive blocks become Shared.
- R8: A snooped read-exclusive (`snp_cmd` = 2) that hits makes the block Invalid, and does not raise `shr_out`. A Modified block flushes its data first.
- R9: A snoop whose tag does not match, or a snooped write-back (`snp_cmd` = 3), has no effect. The tag is address bits above the two index bits `addr[1:0]`.
- R10: A processor request whose index equals the index of a snoop presented in the same cycle is not accepted. A snoop to another index does not delay it.
- R11: `cpu_ready` is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request complete pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Grant; the transaction completes in the granted cycle |
| bus_cmd | output | 2 | 0 none, 1 read-shared, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data from memory |
| shr_in | input | 1 | Wired-OR shared line as seen on the bus |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| shr_out | output | 1 | This cache's drive onto the shared line |
| flush_valid | output | 1 | This cache supplies the snooped block |
| flush_data | output | DATA_W | Flushed data |

## Verification
A wrong coherence state never appears directly at the ports. It shows up as a bus command that is missing or extra on the next access to that block: a read-exclusive where none was due, or no write-back on eviction. It also shows up in the snoop response for that block, the very cycle a snoop reaches it. The bench therefore reads each state back through a later processor access or a probing snoop. It compares the exact command sequence, the flushed data and the shared-line drive, usually within two or three cycles of the transition under test.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;

    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHR = 2'd1,
        L_EXC = 2'd2,
        L_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        C_IDLE  = 3'd0,
        C_EVICT = 3'd1,
        C_FETCH = 3'd2,
        C_OWN   = 3'd3,
        C_DONE  = 3'd4
    } ctl_st_t;

endpackage

// File: rtl/mesi_line_array.sv
`timescale 1ns/1ps
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    // snoop-side read port
    input  logic [IDX_W-1:0]  sa_idx,
    output line_st_t          sa_st,
    output logic [TAG_W-1:0]  sa_tag,
    output logic [DATA_W-1:0] sa_data,
    // sequencer-side read port
    input  logic [IDX_W-1:0]  la_idx,
    output line_st_t          la_st,
    output logic [TAG_W-1:0]  la_tag,
    output logic [DATA_W-1:0] la_data,
    // state-only write (snoop)
    input  logic              ws_en,
    input  logic [IDX_W-1:0]  ws_idx,
    input  line_st_t          ws_st,
    // full write (sequencer)
    input  logic              wf_en,
    input  logic [IDX_W-1:0]  wf_idx,
    input  logic [TAG_W-1:0]  wf_tag,
    input  line_st_t          wf_st,
    input  logic [DATA_W-1:0] wf_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i] <= L_INV;
            end else if (wf_en && wf_idx == IDX_W'(i)) begin
                st_q[i] <= wf_st;
            end else if (ws_en && ws_idx == IDX_W'(i)) begin
                st_q[i] <= ws_st;
            end
        end

        always_ff @(posedge clk) begin
            if (wf_en && wf_idx == IDX_W'(i)) begin
                tag_q[i]  <= wf_tag;
                data_q[i] <= wf_data;
            end
        end
    end

    assign sa_st   = st_q[sa_idx];
    assign sa_tag  = tag_q[sa_idx];
    assign sa_data = data_q[sa_idx];
    assign la_st   = st_q[la_idx];
    assign la_tag  = tag_q[la_idx];
    assign la_data = data_q[la_idx];

    // R10: the index stall keeps snoop and sequencer off the same line
    p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ws_en && wf_en && ws_idx == wf_idx));

endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shr_out,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data,
    output logic              upd_en,
    output line_st_t          upd_st
);
    logic hit;
    assign hit = snp_valid && (line_st != L_INV) && (line_tag == snp_tag);

    always_comb begin
        shr_out     = 1'b0;
        flush_valid = 1'b0;
        upd_en      = 1'b0;
        upd_st      = line_st;
        if (hit) begin
            unique case (snp_cmd)
                BC_RD: begin
                    shr_out     = 1'b1;
                    flush_valid = (line_st == L_MOD);
                    upd_en      = (line_st != L_SHR);
                    upd_st      = L_SHR;
                end
                BC_RDX: begin
                    flush_valid = (line_st == L_MOD);
                    upd_en      = 1'b1;
                    upd_st      = L_INV;
                end
                default: begin
                    upd_en = 1'b0;
                end
            endcase
        end
    end

    assign flush_data = flush_valid ? line_data : '0;

endmodule

// File: rtl/mesi_cpu_ctl.sv
`timescale 1ns/1ps
module mesi_cpu_ctl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              shr_in,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic [IDX_W-1:0]  lk_idx,
    input  line_st_t          lk_st,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output line_st_t          wr_st,
    output logic [DATA_W-1:0] wr_data
);
    ctl_st_t           st_q, st_d;
    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [DATA_W-1:0] rdata_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit, stall, accept;

    assign cur_addr = (st_q == C_IDLE) ? cpu_addr : req_addr;
    assign cur_idx  = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    assign lk_idx   = cur_idx;
    assign hit      = (lk_st != L_INV) && (lk_tag == cur_tag);
    assign stall    = snp_valid && (snp_idx == cpu_addr[IDX_W-1:0]);
    assign accept   = (st_q == C_IDLE) && cpu_req && !stall;

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= C_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                req_we    <= cpu_we;
                req_addr  <= cpu_addr;
                req_wdata <= cpu_wdata;
                if (hit && !cpu_we) rdata_q <= lk_data;
            end
            if (st_q == C_FETCH && bus_gnt) rdata_q <= bus_rdata;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE: begin
                if (accept) begin
                    if (hit)
                        st_d = (cpu_we && lk_st == L_SHR) ? C_OWN : C_DONE;
                    else if (lk_st == L_MOD)
                        st_d = C_EVICT;
                    else
                        st_d = cpu_we ? C_OWN : C_FETCH;
                end
            end
            C_EVICT: begin
                if (lk_st != L_MOD || bus_gnt)
                    st_d = req_we ? C_OWN : C_FETCH;
            end
            C_FETCH: if (bus_gnt) st_d = C_DONE;
            C_OWN:   if (bus_gnt) st_d = C_DONE;
            C_DONE:  st_d = C_IDLE;
            default: st_d = C_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = req_addr;
        bus_wdata = req_wdata;
        wr_en     = 1'b0;
        wr_idx    = cur_idx;
        wr_tag    = cur_tag;
        wr_st     = L_MOD;
        wr_data   = req_wdata;
        cpu_ready = 1'b0;
        unique case (st_q)
            C_IDLE: begin
                if (accept && hit && cpu_we && lk_st != L_SHR) begin
                    wr_en   = 1'b1;
                    wr_st   = L_MOD;
                    wr_data = cpu_wdata;
                end
            end
            C_EVICT: begin
                if (lk_st == L_MOD) begin
                    bus_req   = 1'b1;
                    bus_cmd   = BC_WB;
                    bus_addr  = {lk_tag, req_addr[IDX_W-1:0]};
                    bus_wdata = lk_data;
                end
            end
            C_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = BC_RD;
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_st   = shr_in ? L_SHR : L_EXC;
                    wr_data = bus_rdata;
                end
            end
            C_OWN: begin
                bus_req = 1'b1;
                bus_cmd = BC_RDX;
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_st   = L_MOD;
                    wr_data = req_wdata;
                end
            end
            C_DONE: cpu_ready = 1'b1;
            default: cpu_ready = 1'b0;
        endcase
    end

    assign cpu_rdata = rdata_q;

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_IDLE && cpu_req && stall) |=> (!cpu_ready && !bus_req));

    p_silent_upgrade_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && cpu_we && lk_st == L_EXC)
        |=> (cpu_ready && !bus_req && lk_st == L_MOD));

    p_fill_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_FETCH && bus_gnt && !shr_in) |=> (lk_st == L_EXC));

    p_fill_shr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_FETCH && bus_gnt && shr_in) |=> (lk_st == L_SHR));

    p_own_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_OWN && bus_gnt) |=> (lk_st == L_MOD && lk_data == req_wdata));

    p_evict_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_WB) |=> (bus_req && bus_cmd != BC_WB));

endmodule

// File: rtl/mesi_cache_ctrl.sv
`timescale 1ns/1ps
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              shr_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              shr_out,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    line_st_t          sa_st, la_st, ws_st, wf_st;
    logic [TAG_W-1:0]  sa_tag, la_tag, wf_tag;
    logic [DATA_W-1:0] sa_data, la_data, wf_data;
    logic [IDX_W-1:0]  la_idx, wf_idx;
    logic              ws_en, wf_en;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .sa_idx  (snp_idx),
        .sa_st   (sa_st),
        .sa_tag  (sa_tag),
        .sa_data (sa_data),
        .la_idx  (la_idx),
        .la_st   (la_st),
        .la_tag  (la_tag),
        .la_data (la_data),
        .ws_en   (ws_en),
        .ws_idx  (snp_idx),
        .ws_st   (ws_st),
        .wf_en   (wf_en),
        .wf_idx  (wf_idx),
        .wf_tag  (wf_tag),
        .wf_st   (wf_st),
        .wf_data (wf_data)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (bus_cmd_t'(snp_cmd)),
        .snp_tag     (snp_tag),
        .line_st     (sa_st),
        .line_tag    (sa_tag),
        .line_data   (sa_data),
        .shr_out     (shr_out),
        .flush_valid (flush_valid),
        .flush_data  (flush_data),
        .upd_en      (ws_en),
        .upd_st      (ws_st)
    );

    mesi_cpu_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .shr_in    (shr_in),
        .snp_valid (snp_valid),
        .snp_idx   (snp_idx),
        .lk_idx    (la_idx),
        .lk_st     (la_st),
        .lk_tag    (la_tag),
        .lk_data   (la_data),
        .wr_en     (wf_en),
        .wr_idx    (wf_idx),
        .wr_tag    (wf_tag),
        .wr_st     (wf_st),
        .wr_data   (wf_data)
    );

    // R7: after a flush the block is clean, so an immediate repeat cannot flush
    p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && snp_valid) |=> !(flush_valid && snp_addr == $past(snp_addr)));

endmodule

// File: tb/tb_mesi_cache_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_cache_ctrl;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        shr;
        logic [31:0] exp_rd;
        logic [3:0]  exp_seq;
    } vec_t;

    // seq = last two bus commands, older in [3:2]; 1 RD, 2 RDX, 3 WB
    localparam vec_t VECS [12] = '{
        '{1'b0, 8'h04, 32'h0,         1'b0, 32'h0000_1004, 4'h1}, // R2 fill E
        '{1'b1, 8'h04, 32'hA0A0_0001, 1'b0, 32'h0,         4'h0}, // R4 silent
        '{1'b0, 8'h04, 32'h0,         1'b0, 32'hA0A0_0001, 4'h0}, // R3 hit
        '{1'b0, 8'h08, 32'h0,         1'b1, 32'h0000_1008, 4'hD}, // R6 WB, RD
        '{1'b1, 8'h08, 32'hB0B0_0002, 1'b0, 32'h0,         4'h2}, // R5 S->M
        '{1'b0, 8'h05, 32'h0,         1'b1, 32'h0000_1005, 4'h1}, // R2 fill S
        '{1'b0, 8'h05, 32'h0,         1'b0, 32'h0000_1005, 4'h0}, // R3 hit
        '{1'b1, 8'h06, 32'hC0C0_0003, 1'b0, 32'h0,         4'h2}, // R5 miss
        '{1'b0, 8'h06, 32'h0,         1'b0, 32'hC0C0_0003, 4'h0}, // R3 hit
        '{1'b1, 8'h0A, 32'hD0D0_0004, 1'b0, 32'h0,         4'hE}, // R6 WB, RDX
        '{1'b0, 8'h06, 32'h0,         1'b0, 32'hC0C0_0003, 4'hD}, // R6 WB, RD
        '{1'b0, 8'h0A, 32'h0,         1'b0, 32'hD0D0_0004, 4'h1}  // R6 clean victim
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_gnt;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              shr_in;
    logic              snp_valid;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              shr_out, flush_valid;
    logic [DATA_W-1:0] flush_data;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mesi_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shr_in(shr_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .shr_out(shr_out), .flush_valid(flush_valid), .flush_data(flush_data)
    );

    // memory and bus log
    logic [31:0] mem [256];
    logic [3:0]  blog;
    int          bcnt;
    logic [7:0]  wb_addr;
    logic [31:0] wb_data;

    assign bus_gnt   = bus_req;
    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h1000 + i;
            blog    <= '0;
            bcnt    <= 0;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            if (bus_req && bus_gnt) begin
                blog <= {blog[1:0], bus_cmd};
                bcnt <= bcnt + 1;
                if (bus_cmd == 2'd3) begin
                    mem[bus_addr] <= bus_wdata;
                    wb_addr       <= bus_addr;
                    wb_data       <= bus_wdata;
                end
            end
            if (flush_valid) mem[snp_addr] <= flush_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                          input logic shr, output logic [31:0] rd, output logic [3:0] seq);
        int c0;
        int n;
        int k;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; shr_in = shr;
        c0 = bcnt;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!cpu_ready && k < 50);
        if (!cpu_ready) chk("R11 request never completed", 32'(cpu_ready), 32'd1);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        n = bcnt - c0;
        seq = (n == 0) ? 4'h0 : (n == 1) ? {2'b00, blog[1:0]} : blog;
    endtask

    task automatic snoop_op(input logic [1:0] cmd, input logic [7:0] addr,
                            output logic s, output logic f, output logic [31:0] fd);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
        #2;
        s = shr_out; f = flush_valid; fd = flush_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [3:0]  seq;
        logic        s, f;
        logic [31:0] fd;

        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        shr_in = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 cpu_ready", 32'(cpu_ready), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 shr_out", 32'(shr_out), 32'd0);
        chk("R1 flush_valid", 32'(flush_valid), 32'd0);
        rst_n = 1'b1;
        // R1: every block invalid, so a snoop finds nothing
        snoop_op(2'd1, 8'h00, s, f, fd);
        chk("R1 snoop on empty cache", 32'(s), 32'd0);

        for (int v = 0; v < 12; v++) begin
            cpu_op(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].shr, rd, seq);
            chk($sformatf("R2-R6 vector %0d bus command sequence", v), 32'(seq), 32'(VECS[v].exp_seq));
            if (!VECS[v].we)
                chk($sformatf("R2 R3 vector %0d read data", v), rd, VECS[v].exp_rd);
            @(negedge clk);
            chk("R11 ready is one pulse", 32'(cpu_ready), 32'd0);
        end
        // R6: vector 3 wrote back the dirty block at 0x04
        chk("R6 write-back reached memory", mem[8'h04], 32'hA0A0_0001);

        // R7 snoop read of Modified 0x08
        snoop_op(2'd1, 8'h08, s, f, fd);
        chk("R7 shared on dirty hit", 32'(s), 32'd1);
        chk("R7 flush on dirty hit", 32'(f), 32'd1);
        chk("R7 flush data", fd, 32'hB0B0_0002);
        snoop_op(2'd1, 8'h08, s, f, fd);
        chk("R7 now Shared: shared", 32'(s), 32'd1);
        chk("R7 now Shared: no flush", 32'(f), 32'd0);
        // R7 Exclusive 0x0A drops to Shared, so a write needs ownership
        snoop_op(2'd1, 8'h0A, s, f, fd);
        chk("R7 exclusive hit asserts shared", 32'(s), 32'd1);
        chk("R7 exclusive hit no flush", 32'(f), 32'd0);
        cpu_op(1'b1, 8'h0A, 32'hE1E1_0005, 1'b0, rd, seq);
        chk("R7 R5 write after E->S needs RDX", 32'(seq), 32'h2);
        // R9 tag mismatch and snooped write-back
        snoop_op(2'd1, 8'h09, s, f, fd);
        chk("R9 tag mismatch no shared", 32'(s), 32'd0);
        snoop_op(2'd3, 8'h05, s, f, fd);
        chk("R9 snooped WB no shared", 32'(s), 32'd0);
        chk("R9 snooped WB no flush", 32'(f), 32'd0);
        snoop_op(2'd1, 8'h05, s, f, fd);
        chk("R9 block still Shared", 32'(s), 32'd1);
        // R8 read-exclusive of Modified 0x0A
        snoop_op(2'd2, 8'h0A, s, f, fd);
        chk("R8 flush on RDX", 32'(f), 32'd1);
        chk("R8 flush data", fd, 32'hE1E1_0005);
        chk("R8 no shared on RDX", 32'(s), 32'd0);
        snoop_op(2'd1, 8'h0A, s, f, fd);
        chk("R8 block invalid after RDX", 32'(s), 32'd0);
        cpu_op(1'b0, 8'h0A, 32'h0, 1'b0, rd, seq);
        chk("R8 read after invalidate misses", 32'(seq), 32'h1);
        chk("R8 flushed data reached memory", rd, 32'hE1E1_0005);
        // R8 read-exclusive of Shared 0x05
        snoop_op(2'd2, 8'h05, s, f, fd);
        chk("R8 shared block no flush", 32'(f), 32'd0);
        cpu_op(1'b0, 8'h05, 32'h0, 1'b1, rd, seq);
        chk("R8 shared block invalidated", 32'(seq), 32'h1);
        chk("R2 refill data", rd, 32'h0000_1005);
        // R6 victim address and data
        cpu_op(1'b1, 8'h07, 32'hF0F0_0007, 1'b0, rd, seq);
        chk("R5 write miss RDX", 32'(seq), 32'h2);
        cpu_op(1'b0, 8'h0B, 32'h0, 1'b0, rd, seq);
        chk("R6 WB then RD", 32'(seq), 32'hD);
        chk("R6 victim address", 32'(wb_addr), 32'h07);
        chk("R6 victim data", wb_data, 32'hF0F0_0007);
        chk("R2 fill data", rd, 32'h0000_100B);

        // R10 same-index snoop stalls the request
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h08;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h08;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 stalled: no ready", 32'(cpu_ready), 32'd0);
            chk("R10 stalled: no bus", 32'(bus_req), 32'd0);
        end
        snp_valid = 1'b0;
        @(negedge clk);
        chk("R10 accepted after snoop ends", 32'(cpu_ready), 32'd1);
        chk("R3 hit data after stall", cpu_rdata, 32'hB0B0_0002);
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R11 ready drops", 32'(cpu_ready), 32'd0);

        // R10 other-index snoop does not stall
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h05;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h08;
        @(negedge clk);
        chk("R10 no stall on other index", 32'(cpu_ready), 32'd1);
        snp_valid = 1'b0; cpu_req = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule